// File: doc/BRIEF.md
# Vertical Laplacian Sharpening Filter

This block sharpens a raster image along the sub-scan (vertical) direction. Pixels arrive as an 8-bit stream, one per accepted clock, in main-scan order. Two cascaded single-line delay memories hold the two previous lines. Each incoming pixel is therefore aligned with the pixel in the same column of the line before it and of the line two before it. The middle of these three lines is the centre line N. The older line is A, and the incoming line is B. The filter adds a scaled second difference to the centre pixel: N' = N + K·(2N − A − B). The result is rounded and clamped to 8 bits.

A frame begins with a pixel that carries the frame-start strobe. The line length is captured at that moment. A control state machine tracks how many lines of the frame have been seen. Its states are `S_IDLE` (no frame started yet), `S_FILL0` (first line), `S_FILL1` (second line) and `S_RUN` (filtering). It has four transitions:

- IDLE→FILL0 on frame start.
- FILL0→FILL1 on the last column of a line.
- FILL1→RUN on the last column of a line.
- any state→FILL0 on a new frame start.

During the two fill lines the delay memories are not yet valid, so the incoming pixel is passed through unchanged. The coefficient K is held in a register that can be written at any time.

Top module: `vsharp_filter`

## Requirements
- R1: After reset `pix_out_valid` is 0 and the coefficient register holds 0x10 (K = 1.0).
- R2: Pixels presented while no frame has been started (state `S_IDLE`, `frame_start` low) are ignored: no output pixel is produced for them.
- R3: A pixel with `pix_valid` and `frame_start` both high is column 0 of line 0 of a new frame. `line_len` is captured from that cycle and must lie in 2..MAX_LINE. Columns then advance only on accepted pixels and wrap to 0 after column `line_len`−1.
- R4: The line state advances `S_FILL0`→`S_FILL1`→`S_RUN` only on the last column of a line, and `S_RUN` persists until the next frame start.
- R5: For pixels of lines 0 and 1 of a frame, the output equals the incoming pixel.
- R6: For a pixel of line L ≥ 2 at column c, the inputs are N (line L−1), A (line L−2) and B (line L, the incoming pixel), all at column c. The output is clamp(N + floor((K·(2N−A−B) + 8) / 16)).
- R7: The result is clamped: values below 0 become 0 and values above 255 become 255.
- R8: K is unsigned Q4.4 (bits 7:4 integer, bits 3:0 fraction), loaded from `coef_in` on a cycle with `coef_we` high. K = 0 leaves the centre pixel unchanged.
- R9: Every accepted pixel produces exactly one output, with `pix_out_valid` high exactly 3 clock cycles after the cycle in which the pixel was accepted. Gaps in `pix_valid` do not disturb column alignment.
- R10: A frame start in the middle of a frame restarts the line sequence at `S_FILL0` and column 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_we | input | 1 | Load strobe for the coefficient register |
| coef_in | input | 8 | New coefficient K, unsigned Q4.4 |
| line_len | input | AW+1 | Pixels per line, captured at frame start |
| frame_start | input | 1 | Marks the first pixel of a frame (qualified by `pix_valid`) |
| pix_valid | input | 1 | Input pixel strobe |
| pix_in | input | 8 | Input pixel |
| pix_out_valid | output | 1 | Output pixel strobe |
| pix_out | output | 8 | Sharpened pixel |

## Verification
The hardest case to reach is alignment across lines while `pix_valid` has random gaps. The column counter must stay locked to the memory contents through those gaps. The hardest sequence is a frame start that arrives part-way through a line, with stale data left in both delay memories. The stimulus drives whole frames with random idle cycles, for several line lengths and K values. It then aborts a frame mid-line and starts a new one at once. Directed lines of 0 and 255 force both clamp limits.

// File: rtl/vsharp_pkg.sv
package vsharp_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FILL0 = 2'd1,
        S_FILL1 = 2'd2,
        S_RUN   = 2'd3
    } line_state_e;

    localparam int PIX_W   = 8;
    localparam int COEF_W  = 8;
    localparam int FRAC_W  = 4;
    localparam int LAP_W   = PIX_W + 3;
    localparam int PROD_W  = LAP_W + COEF_W + 1;
    localparam logic [COEF_W-1:0] COEF_UNITY = 8'h10;
endpackage

// File: rtl/vsharp_line_delay.sv
module vsharp_line_delay #(
    parameter int MAX_LINE = 1024,
    parameter int PIX_W    = 8,
    localparam int AW      = $clog2(MAX_LINE)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [PIX_W-1:0] din,
    output logic [PIX_W-1:0] dout
);
    logic [PIX_W-1:0] store [MAX_LINE];

    // old value of this column is read out while the new one is written
    assign dout = store[addr];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[addr] <= din;
        end
    end
endmodule

// File: rtl/vsharp_scan_ctrl.sv
module vsharp_scan_ctrl
    import vsharp_pkg::*;
#(
    parameter int MAX_LINE = 1024,
    localparam int AW      = $clog2(MAX_LINE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_valid,
    input  logic          frame_start,
    input  logic [AW:0]   line_len,
    output logic          accept,
    output logic          bypass,
    output logic [AW-1:0] col
);
    line_state_e   state_q, state_d;
    logic [AW-1:0] col_q;
    logic [AW:0]   len_q;
    logic [AW:0]   len_eff;
    logic          restart;
    logic          last_col;

    assign restart  = pix_valid && frame_start;
    assign accept   = pix_valid && (state_q != S_IDLE || frame_start);
    assign len_eff  = restart ? line_len : len_q;
    assign col      = restart ? '0 : col_q;
    assign last_col = ({1'b0, col} == len_eff - 1'b1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = S_FILL0;
        end else if (accept && last_col) begin
            unique case (state_q)
                S_IDLE:  state_d = S_IDLE;
                S_FILL0: state_d = S_FILL1;
                S_FILL1: state_d = S_RUN;
                S_RUN:   state_d = S_RUN;
            endcase
        end
    end

    // outputs and column bookkeeping
    always_comb begin
        unique case (state_q)
            S_IDLE, S_FILL0, S_FILL1: bypass = 1'b1;
            S_RUN:                    bypass = restart;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            len_q <= '0;
        end else begin
            if (restart) begin
                len_q <= line_len;
            end
            if (accept) begin
                col_q <= last_col ? '0 : col + 1'b1;
            end
        end
    end

    AST_FILL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FILL0 && !restart) |=> (state_q != S_RUN)); // R4
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (state_q == S_FILL0 && col_q == 1)); // R10
    AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |-> ({1'b0, col_q} < len_q)); // R3
endmodule

// File: rtl/vsharp_lap_pipe.sv
module vsharp_lap_pipe
    import vsharp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_bypass,
    input  logic [PIX_W-1:0]  centre,
    input  logic [PIX_W-1:0]  above,
    input  logic [PIX_W-1:0]  below,
    input  logic [COEF_W-1:0] coef,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_pix
);
    localparam int SUM_W = PROD_W - FRAC_W + 1;

    // stage 1: aligned operands
    logic             v1, byp1;
    logic [PIX_W-1:0] n1, a1, b1;
    // stage 2: product
    logic              v2, byp2;
    logic [PIX_W-1:0]  n2;
    logic signed [PROD_W-1:0] prod2;

    logic signed [LAP_W-1:0]  lap1;
    logic signed [PROD_W-1:0] rnd2;
    logic signed [SUM_W-1:0]  sum2;
    logic [PIX_W-1:0]         sat2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0;
            byp1 <= 1'b0;
            n1 <= '0;
            a1 <= '0;
            b1 <= '0;
        end else begin
            v1   <= in_valid;
            byp1 <= in_bypass;
            n1   <= centre;
            a1   <= above;
            b1   <= below;
        end
    end

    assign lap1 = $signed({3'b000, n1} << 1) - $signed({3'b000, a1}) - $signed({3'b000, b1});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2 <= 1'b0;
            byp2 <= 1'b0;
            n2 <= '0;
            prod2 <= '0;
        end else begin
            v2    <= v1;
            byp2  <= byp1;
            n2    <= n1;
            prod2 <= PROD_W'(lap1) * $signed({1'b0, coef});
        end
    end

    assign rnd2 = (prod2 + PROD_W'(1 << (FRAC_W - 1))) >>> FRAC_W;
    assign sum2 = $signed({{(SUM_W-PIX_W){1'b0}}, n2}) + SUM_W'(rnd2);

    always_comb begin
        if (sum2 < 0) begin
            sat2 = '0;
        end else if (sum2 > 255) begin
            sat2 = 8'hFF;
        end else begin
            sat2 = sum2[PIX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= v2;
            out_pix   <= byp2 ? n2 : sat2;
        end
    end

    AST_BYPASS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (v2 && byp2) |=> (out_pix == $past(n2))); // R5
    AST_ZERO_COEF: assert property (@(posedge clk) disable iff (!rst_n)
        (v1 && coef == '0) |=> (prod2 == '0)); // R8
endmodule

// File: rtl/vsharp_filter.sv
module vsharp_filter
    import vsharp_pkg::*;
#(
    parameter int MAX_LINE = 1024,
    localparam int AW      = $clog2(MAX_LINE)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         coef_we,
    input  logic [7:0]   coef_in,
    input  logic [AW:0]  line_len,
    input  logic         frame_start,
    input  logic         pix_valid,
    input  logic [7:0]   pix_in,
    output logic         pix_out_valid,
    output logic [7:0]   pix_out
);
    logic          accept, bypass;
    logic [AW-1:0] col;
    logic [7:0]    prev1, prev2, centre;
    logic [7:0]    coef_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coef_q <= COEF_UNITY;
        end else if (coef_we) begin
            coef_q <= coef_in;
        end
    end

    vsharp_scan_ctrl #(.MAX_LINE(MAX_LINE)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .frame_start(frame_start),
        .line_len(line_len), .accept(accept), .bypass(bypass), .col(col)
    );

    vsharp_line_delay #(.MAX_LINE(MAX_LINE), .PIX_W(PIX_W)) dly1_i (
        .clk(clk), .wr_en(accept), .addr(col), .din(pix_in), .dout(prev1)
    );

    vsharp_line_delay #(.MAX_LINE(MAX_LINE), .PIX_W(PIX_W)) dly2_i (
        .clk(clk), .wr_en(accept), .addr(col), .din(prev1), .dout(prev2)
    );

    assign centre = bypass ? pix_in : prev1;

    vsharp_lap_pipe pipe_i (
        .clk(clk), .rst_n(rst_n), .in_valid(accept), .in_bypass(bypass),
        .centre(centre), .above(prev2), .below(pix_in), .coef(coef_q),
        .out_valid(pix_out_valid), .out_pix(pix_out)
    );

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        pix_out_valid |-> $past(pix_valid, 3)); // R9
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !accept) |-> !frame_start); // R2
endmodule

// File: tb/vsharp_filter_tb_top.sv
module vsharp_filter_tb_top;
    localparam int MAXL = 16;
    localparam int AW   = $clog2(MAXL);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         coef_we = 1'b0;
    logic [7:0]   coef_in = '0;
    logic [AW:0]  line_len = '0;
    logic         frame_start = 1'b0;
    logic         pix_valid = 1'b0;
    logic [7:0]   pix_in = '0;
    logic         pix_out_valid;
    logic [7:0]   pix_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    int exp_val[$];
    int exp_cyc[$];
    int exp_req[$];
    int rows[3][MAXL];
    int k_model = 16;

    always #2 clk = ~clk;

    vsharp_filter #(.MAX_LINE(MAXL)) dut_i (
        .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_in(coef_in),
        .line_len(line_len), .frame_start(frame_start), .pix_valid(pix_valid),
        .pix_in(pix_in), .pix_out_valid(pix_out_valid), .pix_out(pix_out)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // scoreboard: value, arrival cycle and requirement tag per expected output
    always @(negedge clk) begin
        if (rst_n && pix_out_valid) begin
            n_checks++;
            if (exp_val.size() == 0) begin
                n_fail++;
                $display("FAIL R2/R9: unexpected output %0d, expected none", pix_out);
            end else begin
                int v, c, r;
                v = exp_val.pop_front();
                c = exp_cyc.pop_front();
                r = exp_req.pop_front();
                if (pix_out !== v[7:0]) begin
                    n_fail++;
                    $display("FAIL R%0d: pixel %0d, expected %0d", r, pix_out, v);
                end
                if (cyc != c) begin
                    n_fail++;
                    $display("FAIL R9: output at cycle %0d, expected %0d", cyc, c);
                end
            end
        end
    end

    function automatic int model(int n, int a, int b, int k);
        int p, s;
        p = k * (2 * n - a - b);
        s = n + ((p + 8) >>> 4);
        if (s < 0) s = 0;   // R7 low clamp
        if (s > 255) s = 255; // R7 high clamp
        return s;
    endfunction

    task automatic set_k(int k);
        @(negedge clk);
        coef_we = 1'b1;
        coef_in = 8'(k);
        @(negedge clk);
        coef_we = 1'b0;
        k_model = k;
    endtask

    // pattern: 0 random, 1 centre bright / neighbours dark, 2 inverse
    task automatic send_frame(int len, int nlines, int pat, bit gaps, int stop_col);
        for (int l = 0; l < nlines; l++) begin
            for (int c = 0; c < len; c++) begin
                int v;
                if (l == nlines - 1 && c == stop_col) return;
                if (pat == 0) v = $urandom_range(0, 255);
                else if (pat == 1) v = (l % 2 == 1) ? 255 : 0;
                else v = (l % 2 == 1) ? 0 : 255;
                @(negedge clk);
                while (gaps && ($urandom_range(0, 3) == 0)) begin
                    pix_valid = 1'b0;
                    frame_start = 1'b0;
                    @(negedge clk);
                end
                pix_valid   = 1'b1;
                frame_start = (l == 0 && c == 0);
                line_len    = (AW+1)'(len);
                pix_in      = 8'(v);
                rows[l % 3][c] = v;
                if (l < 2) begin
                    exp_val.push_back(v);
                    exp_req.push_back(5); // R5 pass-through
                end else begin
                    exp_val.push_back(model(rows[(l - 1) % 3][c], rows[(l - 2) % 3][c], v, k_model));
                    exp_req.push_back(6); // R6 / R7 / R8 filtered value
                end
                exp_cyc.push_back(cyc + 3); // R9 latency
            end
        end
        @(negedge clk);
        pix_valid = 1'b0;
        frame_start = 1'b0;
    endtask

    task automatic drain();
        repeat (6) @(negedge clk);
        n_checks++;
        if (exp_val.size() != 0) begin
            n_fail++;
            $display("FAIL R9: %0d outputs missing, expected 0", exp_val.size());
            exp_val.delete(); exp_cyc.delete(); exp_req.delete();
        end
    endtask

    initial begin
        int kset[6] = '{0, 16, 8, 24, 4, 255};
        repeat (3) @(negedge clk);
        // R1: reset state
        n_checks++;
        if (pix_out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: pix_out_valid %0b, expected 0", pix_out_valid);
        end
        rst_n = 1'b1;
        // R2: pixels before any frame start are ignored
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            pix_valid = 1'b1;
            pix_in = 8'(i * 7);
        end
        @(negedge clk);
        pix_valid = 1'b0;
        drain(); // no output may have appeared (scoreboard flags it)
        // R1: default K = 1.0 used by first frame
        send_frame(8, 5, 0, 1'b0, -1);
        drain();
        // R3 R4 R6 R8: several K and line lengths, with gaps
        foreach (kset[i]) begin
            set_k(kset[i]);
            send_frame(5, 6, 0, 1'b1, -1);
            send_frame(MAXL, 4, 0, 1'b1, -1);
            send_frame(2, 5, 0, 1'b0, -1);
            drain();
        end
        // R7: both clamp limits
        set_k(255);
        send_frame(6, 6, 1, 1'b0, -1);
        send_frame(6, 6, 2, 1'b1, -1);
        drain();
        // R10: abort mid-line, restart at once
        set_k(20);
        send_frame(7, 4, 0, 1'b1, 3);
        send_frame(7, 5, 0, 1'b1, -1);
        drain();
        done = 1'b1;
    end

    initial begin
        while (!done && cyc < 150000) @(negedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule